// File: doc/BRIEF.md
# Byte-Swapped Interrupt Event Controller

This block collects interrupt events from up to 32 source lines into a pending-event register. It gates them with a mask register and holds a CPU interrupt latch that drives the processor interrupt line. Software reaches it over a simple register port on a little-endian bus. Every data word that crosses the port has its four bytes reversed between bus order and internal order, so bus byte 0 is internal bits 31:24.

Software reads the pending events and writes the mask. It then writes a clear register. A clear write with the global clear-all bit set empties the pending register and drops the CPU interrupt. Any other clear write keeps only the pending bits that are also set in the byte-swapped write data. A source that asserts in the same cycle as a clear always keeps its pending bit. Reads are combinational from the address.

Top module: `swap_irq_ctrl`

## Requirements
- R1: After reset the pending events, the mask and the CPU latch are all zero, and `cpu_irq` is low.
- R2: A read at offset 0x20 returns the pending events with their four bytes reversed. Read selection looks only at offset bits 7:2, so 0x22 also returns the events.
- R3: A write to offset 0x24 stores the write data byte-reversed as the mask. Internal mask bit n enables pending bit n.
- R4: A write to offset 0x28 whose internal bit 31 is set zeroes all pending events and clears the CPU latch. Internal bit 31 is bus bit 7, so the bus value is 0x00000080. `cpu_irq` is low after that edge.
- R5: A write to offset 0x28 with internal bit 31 clear replaces the pending events with pending AND the byte-reversed write data.
- R6: A read at offset 0x34 returns the identifier 0xFFFFBFFF byte-reversed, which is 0xFFBFFFFF on the bus.
- R7: A read at any other offset returns 0. This includes the mask offset 0x24 and 0x30.
- R8: Each cycle, a high bit on `src_evt` sets the matching pending bit at the next clock edge. A held level keeps the bit set.
- R9: The CPU latch sets one clock edge after (pending AND mask) is non-zero. It then stays set, even if the events or the mask are cleared, until a clear-all write.
- R10: A source bit that is high in the same cycle as a clear write (selective or clear-all) is pending after that edge.
- R11: A write takes effect only when the full byte offset matches exactly. Writes to offsets such as 0x25 or 0x29 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | NSRC | Event source lines, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Byte offset of the register access |
| wdata | input | 32 | Write data in bus byte order |
| rdata | output | 32 | Read data in bus byte order, combinational from addr |
| cpu_irq | output | 1 | CPU interrupt line, driven by the latch |

## Verification
The embedded assertions check the per-cycle rules on every cycle:
- source bits are never lost across an edge;
- the latch holds until a clear-all write and only rises after masked events were present;
- the mask changes only on an exact mask write;
- a clear-all write with no new sources leaves nothing pending and no interrupt.

The bus-side byte reversal can only be shown by the bench's directed scenarios, since it needs known written and expected words. The same holds for the identifier value, the zero return on unknown offsets, the partial-offset behaviour of reads versus writes, and the one-cycle delay of the latch.

// File: rtl/swap_irq_ctrl.sv
module swap_irq_ctrl #(
  parameter int NSRC = 32,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic            cpu_irq
);
  localparam logic [AW-1:0] OFS_EVT  = AW'(8'h20);
  localparam logic [AW-1:0] OFS_MASK = AW'(8'h24);
  localparam logic [AW-1:0] OFS_CLR  = AW'(8'h28);
  localparam logic [AW-1:0] OFS_ID   = AW'(8'h34);
  localparam logic [31:0]   ID_VAL   = 32'hFFFF_BFFF;
  localparam int            CLRALL   = 31;

  function automatic logic [31:0] bswap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  logic [NSRC-1:0] pend, mask;
  logic            latch;
  logic [31:0]     wd_int;
  logic            wr_mask, wr_clr, clr_all;
  logic [NSRC-1:0] pend_kept;

  assign wd_int   = bswap(wdata);
  assign wr_mask  = wr_en && (addr == OFS_MASK);
  assign wr_clr   = wr_en && (addr == OFS_CLR);
  assign clr_all  = wr_clr && wd_int[CLRALL];
  assign pend_kept = clr_all ? '0 : (wr_clr ? (pend & wd_int[NSRC-1:0]) : pend);
  assign cpu_irq  = latch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= '0;
      mask  <= '0;
      latch <= 1'b0;
    end else begin
      pend <= pend_kept | src_evt;
      if (wr_mask) mask <= wd_int[NSRC-1:0];
      if (clr_all) latch <= 1'b0;
      else if (|(pend & mask)) latch <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr[AW-1:2] == OFS_EVT[AW-1:2])     rdata = bswap(32'(pend));
    else if (addr[AW-1:2] == OFS_ID[AW-1:2]) rdata = bswap(ID_VAL);
  end

  assert_src_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(src_evt)) == $past(src_evt)));

  assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && !clr_all) |=> cpu_irq);

  assert_latch_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_irq && (pend & mask) == '0) |=> !cpu_irq);

  assert_clear_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && src_evt == '0) |=> (pend == '0 && !cpu_irq));

  assert_mask_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask));
endmodule

// File: tb/swap_irq_ctrl_bench.sv
module swap_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [31:0] src_evt = '0, wdata = '0, rdata;
  logic [7:0]  addr = '0;
  logic        cpu_irq;
  int checks = 0, failures = 0;

  swap_irq_ctrl u_swap_irq_ctrl (.clk(clk), .rst_n(rst_n), .src_evt(src_evt),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .cpu_irq(cpu_irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [31:0] s = '0);
    @(negedge clk); wr_en = 1; addr = a; wdata = d; src_evt = s;
    @(negedge clk); wr_en = 0; src_evt = '0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a; #1 chk(req, rdata, exp);
  endtask

  task automatic pulse(input logic [31:0] s);
    @(negedge clk); src_evt = s; @(negedge clk); src_evt = '0;
  endtask

  task automatic t_reset();
    rd("R1", 8'h20, 32'h0);
    chk("R1", {31'b0, cpu_irq}, 32'h0);
    rd("R6", 8'h34, 32'hFFBF_FFFF);
  endtask

  task automatic t_events();
    pulse(32'h0000_0001);
    rd("R2", 8'h20, 32'h0100_0000);
    rd("R2", 8'h22, 32'h0100_0000);
    rd("R7", 8'h24, 32'h0);
    rd("R7", 8'h30, 32'h0);
    chk("R8", {31'b0, cpu_irq}, 32'h0);
  endtask

  task automatic t_selective();
    pulse(32'h0000_00F0);
    rd("R8", 8'h20, 32'hF100_0000);
    wr(8'h28, 32'h3100_0000);
    rd("R5", 8'h20, 32'h3100_0000);
  endtask

  task automatic t_mask_latch();
    @(negedge clk); wr_en = 1; addr = 8'h24; wdata = 32'h0100_0000;
    @(negedge clk); wr_en = 0;
    chk("R9", {31'b0, cpu_irq}, 32'h0);
    @(negedge clk);
    chk("R3", {31'b0, cpu_irq}, 32'h1);
    wr(8'h28, 32'h0);
    rd("R5", 8'h20, 32'h0);
    chk("R9", {31'b0, cpu_irq}, 32'h1);
    wr(8'h24, 32'h0);
    @(negedge clk);
    chk("R9", {31'b0, cpu_irq}, 32'h1);
  endtask

  task automatic t_clear_all();
    pulse(32'h0000_0300);
    wr(8'h28, 32'h0000_0080);
    rd("R4", 8'h20, 32'h0);
    chk("R4", {31'b0, cpu_irq}, 32'h0);
  endtask

  task automatic t_priority();
    wr(8'h24, 32'h0100_0000);
    wr(8'h28, 32'h0000_0080, 32'h0000_0002);
    rd("R10", 8'h20, 32'h0200_0000);
    chk("R10", {31'b0, cpu_irq}, 32'h0);
    wr(8'h28, 32'h0, 32'h0000_0001);
    rd("R10", 8'h20, 32'h0100_0000);
    @(negedge clk);
    chk("R10", {31'b0, cpu_irq}, 32'h1);
    @(negedge clk); src_evt = 32'h0000_0010;
    @(negedge clk); wr_en = 1; addr = 8'h28; wdata = 32'h0;
    @(negedge clk); wr_en = 0;
    @(negedge clk); src_evt = '0; addr = 8'h20; #1
    chk("R8", rdata, 32'h1000_0000);
    wr(8'h28, 32'h0000_0080);
    wr(8'h24, 32'h0);
  endtask

  task automatic t_ignored();
    pulse(32'h0000_0004);
    wr(8'h29, 32'h0000_0080);
    rd("R11", 8'h20, 32'h0400_0000);
    wr(8'h25, 32'h0400_0000);
    @(negedge clk); @(negedge clk);
    chk("R11", {31'b0, cpu_irq}, 32'h0);
    wr(8'h24, 32'h0400_0000);
    @(negedge clk);
    chk("R3", {31'b0, cpu_irq}, 32'h1);
    wr(8'h28, 32'h0000_0080);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_events();
    t_selective();
    t_mask_latch();
    t_clear_all();
    t_priority();
    t_ignored();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule